// File: doc/BRIEF.md
# Serial Channel Interrupt Aggregator

This block is the global control region of a bridge that carries several serial channels behind one 32-bit memory-mapped register bus. It gathers one interrupt-request level from each channel into a status vector. It holds an interrupt enable mask and a wake enable mask. It drives a single level-sensitive interrupt line whenever an enabled channel is requesting.

Each enable mask has two addresses. One address sets the bits written as one, and the other clears them. The clear address reads back the mask inverted, so software can use either view.

Bus addresses below the window base select the global registers. Addresses at or above the window base are split into a channel index and a local offset, using a fixed stride. A window hit on a configured channel, below the DMA sub-region, is forwarded to the channel side as a one-cycle select, together with the index, offset, direction and write data. The channel's read data comes back on the same cycle. Reads return one cycle after the request. The channel count is a parameter between 1 and the maximum.

Top module: `uih_top`

## Requirements
- R1: Reading byte offset 0x00 returns 0x00070002, and reading offset 0x04 returns the configured channel count NUM_CH.
- R2: Reading offset 0x08 returns the status vector. Bit i is 1 when channel i's request input was high on the previous clock edge. Bits at index NUM_CH and above always read 0.
- R3: A write to offset 0x0C ORs data bits [MAX_CH-1:0] into the interrupt enable mask. Reading 0x0C returns the mask, zero-extended to 32 bits.
- R4: A write to offset 0x10 clears every interrupt enable bit where the data is 1. Reading 0x10 returns the bitwise inverse of the zero-extended 32-bit mask, so bits MAX_CH and above read 1.
- R5: The wake mask is set through offset 0x14 and cleared through offset 0x18, with the same readback rules as R3 and R4. It never affects irq_out.
- R6: irq_out is a register. After each clock edge it is 1 exactly when (status AND interrupt enable) is nonzero, using the values those registers take at that same edge. A request change and an enable write in the same cycle both appear in irq_out one cycle later.
- R7: For an address A at or above 0x1000, the channel index is (A-0x1000)/0x200 and the local offset is (A-0x1000) mod 0x200. When the index is below NUM_CH and the offset is below 0x100, ch_sel is high in the same cycle as bus_valid. In that cycle ch_idx, ch_offset, ch_write and ch_wdata carry the access. A read then returns ch_rdata as sampled in that cycle.
- R8: A window access with local offset 0x100 or above, or with an index of NUM_CH or more, does not raise ch_sel and reads as 0.
- R9: Writes to offsets 0x00, 0x04 and 0x08 change no state. A global offset with no register behind it reads as 0.
- R10: A synchronous reset clears the status vector, both masks, irq_out and bus_rvalid.
- R11: bus_rvalid is high in exactly the cycle after a read request (bus_valid high, bus_write low), with the read data on bus_rdata. Writes produce no bus_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| ch_req | input | MAX_CH | Per-channel interrupt request levels |
| ch_sel | output | 1 | Forwarded channel access strobe |
| ch_write | output | 1 | Direction of the forwarded access |
| ch_idx | output | CH_W | Channel index of the forwarded access |
| ch_offset | output | LOC_W | Local offset inside the channel window |
| ch_wdata | output | 32 | Forwarded write data |
| ch_rdata | input | 32 | Channel read data, sampled while ch_sel is high |
| irq_out | output | 1 | Level interrupt output |

## Verification
The bench builds the block with NUM_CH=6 out of MAX_CH=16 and a 16-bit address. This makes status bits 6 to 15 observable: they can be driven high while they must stay at zero. It also puts whole channel windows, starting at 0x1C00, beyond the configured count, and leaves mask bits above the channel count writable. The channel side returns read data made from the forwarded index and offset. Each forwarded read therefore shows, through the bus alone, whether the decode picked the right window.

// File: rtl/uih_pkg.sv
package uih_pkg;

  localparam int DATA_W = 32;

  localparam logic [DATA_W-1:0] ID_VALUE = 32'h0007_0002;

  localparam int OFS_ID     = 'h00;
  localparam int OFS_COUNT  = 'h04;
  localparam int OFS_STATUS = 'h08;
  localparam int OFS_EN_SET = 'h0C;
  localparam int OFS_EN_CLR = 'h10;
  localparam int OFS_WK_SET = 'h14;
  localparam int OFS_WK_CLR = 'h18;

  typedef enum logic [2:0] {
    GR_ID,
    GR_COUNT,
    GR_STATUS,
    GR_EN_SET,
    GR_EN_CLR,
    GR_WK_SET,
    GR_WK_CLR,
    GR_NONE
  } greg_e;

endpackage

// File: rtl/uih_decode.sv
module uih_decode
  import uih_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_CH     = 8,
  parameter int CH_W       = 4,
  parameter int LOC_W      = 9,
  parameter int WIN_BASE   = 'h1000,
  parameter int WIN_STRIDE = 'h200,
  parameter int DMA_OFS    = 'h100
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              glob,
  output greg_e             greg,
  output logic              fwd,
  output logic [CH_W-1:0]   idx,
  output logic [LOC_W-1:0]  loc
);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] idx_full;
  logic [ADDR_W-1:0] loc_full;

  assign glob     = addr < ADDR_W'(WIN_BASE);
  assign rel      = addr - ADDR_W'(WIN_BASE);
  assign idx_full = rel / ADDR_W'(WIN_STRIDE);
  assign loc_full = rel % ADDR_W'(WIN_STRIDE);

  assign fwd = !glob
            && (idx_full < ADDR_W'(NUM_CH))
            && (loc_full < ADDR_W'(DMA_OFS));
  assign idx = idx_full[CH_W-1:0];
  assign loc = loc_full[LOC_W-1:0];

  always_comb begin
    greg = GR_NONE;
    if (glob) begin
      case (addr)
        ADDR_W'(OFS_ID):     greg = GR_ID;
        ADDR_W'(OFS_COUNT):  greg = GR_COUNT;
        ADDR_W'(OFS_STATUS): greg = GR_STATUS;
        ADDR_W'(OFS_EN_SET): greg = GR_EN_SET;
        ADDR_W'(OFS_EN_CLR): greg = GR_EN_CLR;
        ADDR_W'(OFS_WK_SET): greg = GR_WK_SET;
        ADDR_W'(OFS_WK_CLR): greg = GR_WK_CLR;
        default:             greg = GR_NONE;
      endcase
    end
  end

endmodule

// File: rtl/uih_mask_reg.sv
module uih_mask_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] data,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mask_d
);

  always_comb begin
    mask_d = mask_q;
    if (set_en) mask_d = mask_d | data;
    if (clr_en) mask_d = mask_d & ~data;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clr_en) |=> ((mask_q & $past(data)) == $past(data)));

  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> ((mask_q & $past(data)) == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_en && !clr_en) |=> $stable(mask_q));

endmodule

// File: rtl/uih_status.sv
module uih_status #(
  parameter int MAX_CH = 16,
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MAX_CH-1:0] req,
  output logic [MAX_CH-1:0] status_q,
  output logic [MAX_CH-1:0] status_d
);

  logic [MAX_CH-1:0] live;

  for (genvar i = 0; i < MAX_CH; i++) begin : g_bit
    if (i < NUM_CH) begin : g_live
      assign live[i] = 1'b1;
    end else begin : g_dead
      assign live[i] = 1'b0;
    end
  end

  assign status_d = req & live;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

endmodule

// File: rtl/uih_top.sv
module uih_top
  import uih_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MAX_CH     = 16,
  parameter int NUM_CH     = 8,
  parameter int WIN_BASE   = 'h1000,
  parameter int WIN_STRIDE = 'h200,
  parameter int DMA_OFS    = 'h100,
  localparam int CH_W      = $clog2(MAX_CH),
  localparam int LOC_W     = $clog2(WIN_STRIDE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [MAX_CH-1:0] ch_req,
  output logic              ch_sel,
  output logic              ch_write,
  output logic [CH_W-1:0]   ch_idx,
  output logic [LOC_W-1:0]  ch_offset,
  output logic [31:0]       ch_wdata,
  input  logic [31:0]       ch_rdata,
  output logic              irq_out
);

  logic              glob;
  logic              fwd;
  greg_e             greg;
  logic              rd_req;
  logic              wr_req;
  logic [MAX_CH-1:0] status_q, status_d;
  logic [MAX_CH-1:0] en_q, en_d;
  logic [MAX_CH-1:0] wk_q, wk_d;
  logic              en_set, en_clr, wk_set, wk_clr;
  logic [31:0]       rdata_d;
  logic [31:0]       rdata_q;
  logic              rvalid_q;
  logic              irq_q;

  assign rd_req = bus_valid && !bus_write;
  assign wr_req = bus_valid && bus_write;

  uih_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_W(CH_W), .LOC_W(LOC_W),
    .WIN_BASE(WIN_BASE), .WIN_STRIDE(WIN_STRIDE), .DMA_OFS(DMA_OFS)
  ) u_dec (
    .addr(bus_addr), .glob(glob), .greg(greg), .fwd(fwd),
    .idx(ch_idx), .loc(ch_offset)
  );

  uih_status #(.MAX_CH(MAX_CH), .NUM_CH(NUM_CH)) u_sts (
    .clk(clk), .rst(rst), .req(ch_req),
    .status_q(status_q), .status_d(status_d)
  );

  assign en_set = wr_req && (greg == GR_EN_SET);
  assign en_clr = wr_req && (greg == GR_EN_CLR);
  assign wk_set = wr_req && (greg == GR_WK_SET);
  assign wk_clr = wr_req && (greg == GR_WK_CLR);

  uih_mask_reg #(.W(MAX_CH)) u_en (
    .clk(clk), .rst(rst), .set_en(en_set), .clr_en(en_clr),
    .data(bus_wdata[MAX_CH-1:0]), .mask_q(en_q), .mask_d(en_d)
  );

  uih_mask_reg #(.W(MAX_CH)) u_wk (
    .clk(clk), .rst(rst), .set_en(wk_set), .clr_en(wk_clr),
    .data(bus_wdata[MAX_CH-1:0]), .mask_q(wk_q), .mask_d(wk_d)
  );

  // forwarded channel access, same cycle as the bus request
  assign ch_sel   = bus_valid && fwd;
  assign ch_write = bus_write;
  assign ch_wdata = bus_wdata;

  always_comb begin
    rdata_d = '0;
    if (glob) begin
      case (greg)
        GR_ID:     rdata_d = ID_VALUE;
        GR_COUNT:  rdata_d = 32'(NUM_CH);
        GR_STATUS: rdata_d = 32'(status_q);
        GR_EN_SET: rdata_d = 32'(en_q);
        GR_EN_CLR: rdata_d = ~32'(en_q);
        GR_WK_SET: rdata_d = 32'(wk_q);
        GR_WK_CLR: rdata_d = ~32'(wk_q);
        default:   rdata_d = '0;
      endcase
    end else if (fwd) begin
      rdata_d = ch_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rdata_d;
      irq_q    <= |(status_d & en_d);
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign irq_out    = irq_q;

  // R11
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid);

  // R11
  no_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !bus_rvalid);

  // R7
  fwd_range_chk: assert property (@(posedge clk) disable iff (rst)
    ch_sel |-> ((ch_idx < CH_W'(NUM_CH)) && (ch_offset < LOC_W'(DMA_OFS))));

  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ((en_q == '0) && !en_set) |=> !irq_out);

  // R5
  wake_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ((en_q == '0) && !en_set && (wk_set || wk_clr)) |=> !irq_out);

endmodule

// File: tb/tb_uih_top.sv
module tb_uih_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int MAX_CH     = 16;
  localparam int NUM_CH     = 6;
  localparam int CH_W       = 4;
  localparam int LOC_W      = 9;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic [MAX_CH-1:0] ch_req = '0;
  logic              ch_sel;
  logic              ch_write;
  logic [CH_W-1:0]   ch_idx;
  logic [LOC_W-1:0]  ch_offset;
  logic [31:0]       ch_wdata;
  logic [31:0]       ch_rdata;
  logic              irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // channel side: data built from the forwarded index and offset
  assign ch_rdata = {8'hA5, 4'h0, ch_idx, 7'h0, ch_offset};

  uih_top #(
    .ADDR_W(ADDR_W), .MAX_CH(MAX_CH), .NUM_CH(NUM_CH)
  ) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ch_req(ch_req), .ch_sel(ch_sel),
    .ch_write(ch_write), .ch_idx(ch_idx), .ch_offset(ch_offset),
    .ch_wdata(ch_wdata), .ch_rdata(ch_rdata), .irq_out(irq_out)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results come out
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(32'd1, 32'd0, "R11 unexpected rvalid");
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(bus_rdata, e, t);
      end
    end
  end

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr_req(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                        input logic [MAX_CH-1:0] r);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; ch_req = r;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic set_req(input logic [MAX_CH-1:0] r);
    @(negedge clk);
    ch_req = r;
    @(posedge clk); #1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    check(32'(irq_out), 32'(e), tag);
  endtask

  // forwarded access: checks the channel side in the request cycle
  task automatic win(input bit w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                     input bit e_sel, input logic [CH_W-1:0] e_idx,
                     input logic [LOC_W-1:0] e_off, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    if (!w) begin
      exp_q.push_back(e_sel ? {8'hA5, 4'h0, e_idx, 7'h0, e_off} : 32'h0);
      tag_q.push_back(tag);
    end
    #1;
    check(32'(ch_sel), 32'(e_sel), tag);
    if (e_sel) begin
      check(32'(ch_idx), 32'(e_idx), tag);
      check(32'(ch_offset), 32'(e_off), tag);
      check(32'(ch_write), 32'(w), tag);
      if (w) check(ch_wdata, d, tag);
    end
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(32'(irq_out), 32'd0, "R10 irq after reset");
    check(32'(bus_rvalid), 32'd0, "R10 rvalid after reset");
    rd('h0C, 32'h0, "R10 enable mask zero");
    rd('h14, 32'h0, "R10 wake mask zero");
    rd('h08, 32'h0, "R10 status zero");

    // R1 identifier and count
    rd('h00, 32'h0007_0002, "R1 identifier");
    rd('h04, 32'd6, "R1 channel count");

    // R9 read-only writes and unmapped reads
    wr('h00, 32'hFFFF_FFFF);
    wr('h04, 32'hFFFF_FFFF);
    wr('h08, 32'hFFFF_FFFF);
    rd('h00, 32'h0007_0002, "R9 identifier unchanged");
    rd('h04, 32'd6, "R9 count unchanged");
    rd('h08, 32'h0, "R9 status unchanged");
    rd('h0C, 32'h0, "R9 enable untouched");
    rd('h1C, 32'h0, "R9 unmapped global");
    rd('h800, 32'h0, "R9 unmapped global high");

    // R2 status follows requests, upper bits masked
    set_req(16'hFFFF);
    rd('h08, 32'h0000_003F, "R2 status all requests");
    chk_irq(1'b0, "R6 no enable no irq");
    set_req(16'hFFC0);
    rd('h08, 32'h0, "R2 bits above count stay zero");
    set_req(16'h0024);
    rd('h08, 32'h0000_0024, "R2 status pattern");

    // R3 set
    wr('h0C, 32'h0000_0001);
    chk_irq(1'b0, "R6 enabled bit idle");
    wr('h0C, 32'h0000_0004);
    chk_irq(1'b1, "R6 enabled bit requesting");
    wr('h0C, 32'h0001_8010);
    rd('h0C, 32'h0000_8015, "R3 set accumulates");

    // R4 clear and inverted readback
    wr('h10, 32'h0000_0011);
    rd('h0C, 32'h0000_8004, "R4 clear bits");
    rd('h10, 32'hFFFF_7FFB, "R4 inverted readback");
    chk_irq(1'b1, "R6 irq held by bit 2");
    set_req(16'h0020);
    chk_irq(1'b0, "R6 request dropped");

    // R6 simultaneous request and enable change
    wr_req('h0C, 32'h0000_0010, 16'h0010);
    chk_irq(1'b1, "R6 combined set");
    wr_req('h10, 32'h0000_0010, 16'h0004);
    chk_irq(1'b1, "R6 combined clear keeps bit 2");
    wr('h10, 32'hFFFF_FFFF);
    chk_irq(1'b0, "R6 all disabled");

    // R5 wake mask
    set_req(16'h003F);
    wr('h14, 32'h0000_FFFF);
    chk_irq(1'b0, "R5 wake no irq");
    rd('h14, 32'h0000_FFFF, "R5 wake set");
    wr('h18, 32'h0000_00F0);
    rd('h14, 32'h0000_FF0F, "R5 wake clear");
    rd('h18, 32'hFFFF_00F0, "R5 wake inverted");
    chk_irq(1'b0, "R5 wake still no irq");

    // R7 forwarded window accesses
    win(1'b0, 16'h1000 + 3*16'h200 + 16'h024, 32'h0, 1'b1, 4'd3, 9'h024, "R7 read ch3");
    win(1'b0, 16'h1000, 32'h0, 1'b1, 4'd0, 9'h000, "R7 read ch0");
    win(1'b1, 16'h1000 + 5*16'h200 + 16'h0FC, 32'hDEAD_BEEF, 1'b1, 4'd5, 9'h0FC, "R7 write ch5");

    // R8 DMA region and out-of-range channels
    win(1'b0, 16'h1000 + 2*16'h200 + 16'h100, 32'h0, 1'b0, 4'd0, 9'h0, "R8 DMA region read");
    win(1'b1, 16'h1000 + 1*16'h200 + 16'h1F0, 32'h1234_5678, 1'b0, 4'd0, 9'h0, "R8 DMA region write");
    win(1'b0, 16'h1C00, 32'h0, 1'b0, 4'd0, 9'h0, "R8 channel at count");
    win(1'b1, 16'h1000 + 7*16'h200 + 16'h010, 32'h1, 1'b0, 4'd0, 9'h0, "R8 channel beyond count");
    rd('h0C, 32'h0, "R8 no side effect on enable");

    // R11 write gives no rvalid
    wr('h0C, 32'h0000_0002);
    @(negedge clk);
    check(32'(bus_rvalid), 32'd0, "R11 no rvalid after write");
    chk_irq(1'b1, "R6 enable with active request");

    // R10 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(32'(irq_out), 32'd0, "R10 irq cleared by reset");
    rd('h0C, 32'h0, "R10 enable cleared");
    rd('h14, 32'h0, "R10 wake cleared");
    rd('h08, 32'h0000_003F, "R2 status resumes after reset");

    repeat (3) @(negedge clk);
    check(32'(exp_q.size()), 32'd0, "R11 all reads answered");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule